// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Status Flags

This block moves 8-bit bytes over a clocked serial link. It drives the link's serial clock, which it derives from the system clock. It shifts a byte out on one line and shifts a byte in on another at the same time. A small register port lets a host do four things: write the next byte to send, read the last byte received, read and clear the flags, and switch the transmitter and receiver on or off. Both data paths are double-buffered, so the host can write the next byte while the current one is still shifting.

Three flags report progress:

- Transmit-empty means the host may write a new byte.
- Receive-full means a complete byte is waiting to be read.
- Overrun means a byte arrived while the previous one was still unread.

Accessing the data registers updates transmit-empty and receive-full without any further action by the host. An overrun halts all shifting until the host clears it.

With only the receiver enabled, the serial clock runs without pause. With the transmitter enabled, a frame runs only while a byte is waiting. A frame is one pass of the serial clock that transfers 8 bits.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A write to the transmit data register (address 0) clears transmit-empty (status bit 0) on the following cycle.
- R2: A read access to the receive data register (address 1) clears receive-full (status bit 1), unless a frame is stored in that same cycle.
- R3: When a frame ends with the receiver enabled, receive-full already 1 and no read of address 1 in that cycle, overrun (status bit 2) is set. The receive data register keeps the older byte and the new byte is discarded.
- R4: While overrun is 1 no frame starts, so the serial clock stays high. Writing the status register (address 2) with bit 2 at 0 clears overrun; writing it with bit 2 at 1 leaves overrun at 1.
- R5: A frame has 8 bits, least significant first, so bit 7 is the last bit shifted. Each bit lasts DIV system clocks. The serial clock is low for the first half of each bit and high for the second half. Output data changes when the serial clock falls, input data is sampled when it rises, and the received byte matches the input bits in that order.
- R6: When a frame ends with the transmitter enabled and a byte waiting, that byte starts shifting at once with no gap, and transmit-empty returns to 1.
- R7: When no byte is waiting, the serial clock and the data output both rest high after the frame.
- R8: When the control register (address 3, bit 0 transmit enable, bit 1 receive enable) is written with both enables 0, the serial clock and the data output are high on the next cycle and no further edges occur.
- R9: After reset, the status reads 0x01, the control reads 0x00, and the serial clock and data output are high.
- R10: If a frame ends in the same cycle as a read of address 1 while receive-full is 1, the new byte is stored, receive-full stays 1 and overrun stays 0.
- R11: If the host writes address 0 in the same cycle that a waiting byte moves into the shifter, transmit-empty stays 0 and the newly written byte is sent in the next frame.
- R12: With only the receiver enabled, frames run one after another and each captured byte is stored until an overrun stops them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register select: 0 transmit data, 1 receive data, 2 status, 3 control |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register (combinational) |
| sclk_o | output | 1 | Serial clock, idle high |
| txd_o | output | 1 | Serial data out, idle high |
| rxd_i | input | 1 | Serial data in |

## Verification
The end of a frame can fall in the same cycle as a host access, and the flags must then follow R10 and R11 rather than the plain set or clear rules. The bench counts rising serial-clock edges to find the cycle in which the 8th bit is sampled. It then waits exactly the remaining half bit and issues a receive read or a transmit write in the frame-end cycle. The results are judged from the status bits and from the bytes that later appear on the serial line and in the receive register.

// File: rtl/sst_pkg.sv
package sst_pkg;

   typedef enum logic [1:0] {
      REG_TXD  = 2'd0,
      REG_RXD  = 2'd1,
      REG_STAT = 2'd2,
      REG_CTRL = 2'd3
   } sst_reg_e;

   localparam int ST_TXE = 0;
   localparam int ST_RXF = 1;
   localparam int ST_OVR = 2;

   localparam int CT_TE = 0;
   localparam int CT_RE = 1;

endpackage

// File: rtl/sst_regs.sv
module sst_regs
   import sst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   input  logic              store,
   input  logic              ovr_evt,
   input  logic [DATA_W-1:0] rsr,
   output logic [DATA_W-1:0] rdata,
   output logic              te,
   output logic              re,
   output logic              ovr,
   output logic              tx_empty,
   output logic              rx_full,
   output logic [DATA_W-1:0] tdr,
   output logic              rd_rdr
);

   logic              tdr_wr;
   logic              stat_wr;
   logic              ctrl_wr;
   logic [DATA_W-1:0] rdr;

   assign tdr_wr  = wr_en && (addr == REG_TXD);
   assign stat_wr = wr_en && (addr == REG_STAT);
   assign ctrl_wr = wr_en && (addr == REG_CTRL);
   assign rd_rdr  = rd_en && (addr == REG_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr <= '0;
         rdr <= '0;
         te  <= 1'b0;
         re  <= 1'b0;
      end else begin
         if (tdr_wr)  tdr <= wdata;
         if (store)   rdr <= rsr;
         if (ctrl_wr) begin
            te <= wdata[CT_TE];
            re <= wdata[CT_RE];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty <= 1'b1;
         rx_full  <= 1'b0;
         ovr      <= 1'b0;
      end else begin
         if (tdr_wr)
            tx_empty <= 1'b0;
         else if (load)
            tx_empty <= 1'b1;

         if (store)
            rx_full <= 1'b1;
         else if (rd_rdr)
            rx_full <= 1'b0;

         if (ovr_evt)
            ovr <= 1'b1;
         else if (stat_wr && !wdata[ST_OVR])
            ovr <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_TXD:  rdata = tdr;
         REG_RXD:  rdata = rdr;
         REG_STAT: begin
            rdata[ST_TXE] = tx_empty;
            rdata[ST_RXF] = rx_full;
            rdata[ST_OVR] = ovr;
         end
         default: begin
            rdata[CT_TE] = te;
            rdata[CT_RE] = re;
         end
      endcase
   end

   AST_TXE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tdr_wr |=> !tx_empty); // R1
   AST_RXF_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rdr && !store) |=> !rx_full); // R2
   AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ($stable(rdr) && ovr)); // R3
   AST_OVR_ONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && stat_wr && wdata[ST_OVR]) |=> ovr); // R4
   AST_LOAD_SETS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !tdr_wr) |=> tx_empty); // R6
   AST_READ_MEETS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (store && rd_rdr) |=> (rx_full && !ovr)); // R10
   AST_WRITE_MEETS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tdr_wr) |=> !tx_empty); // R11

endmodule

// File: rtl/sst_engine.sv
module sst_engine #(
   parameter int DATA_W = 8,
   parameter int DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              te,
   input  logic              re,
   input  logic              ovr,
   input  logic              tx_empty,
   input  logic              rx_full,
   input  logic              rd_rdr,
   input  logic [DATA_W-1:0] tdr,
   input  logic              rxd,
   output logic              load,
   output logic              store,
   output logic              ovr_evt,
   output logic [DATA_W-1:0] rsr,
   output logic              sclk_o,
   output logic              txd_o
);

   localparam int HALF = DIV / 2;
   localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int BW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("sst_engine: DIV must be even and at least 2");
   end
   if (DATA_W < 3) begin : g_bad_width
      $error("sst_engine: DATA_W must be at least 3");
   end

   logic              active;
   logic [PW-1:0]     ph;
   logic [BW-1:0]     bit_i;
   logic [DATA_W-1:0] tsr;
   logic              at_half;
   logic              at_last;
   logic              frame_end;
   logic              run_any;
   logic              start_ok;
   logic              start_now;

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      assign at_last = &ph;
   end else begin : g_general
      assign at_last = (ph == PW'(DIV - 1));
   end

   assign at_half   = (ph == PW'(HALF - 1));
   assign run_any   = te | re;
   assign frame_end = active && at_last && (bit_i == BW'(DATA_W - 1));
   assign store     = frame_end && re && (!rx_full || rd_rdr);
   assign ovr_evt   = frame_end && re && rx_full && !rd_rdr;
   assign start_ok  = !ovr && ((te && !tx_empty) || (re && !te));
   assign start_now = run_any && start_ok && (!active || (frame_end && !ovr_evt));
   assign load      = start_now && te;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= '0;
         bit_i  <= '0;
         tsr    <= '0;
         rsr    <= '0;
         sclk_o <= 1'b1;
         txd_o  <= 1'b1;
      end else if (!run_any) begin
         active <= 1'b0;
         ph     <= '0;
         bit_i  <= '0;
         sclk_o <= 1'b1;
         txd_o  <= 1'b1;
      end else if (start_now) begin
         active <= 1'b1;
         ph     <= '0;
         bit_i  <= '0;
         sclk_o <= 1'b0;
         tsr    <= tdr;
         txd_o  <= te ? tdr[0] : 1'b1;
      end else if (active) begin
         if (at_half) begin
            sclk_o <= 1'b1;
            rsr    <= {rxd, rsr[DATA_W-1:1]};
            ph     <= ph + 1'b1;
         end else if (at_last) begin
            if (bit_i == BW'(DATA_W - 1)) begin
               active <= 1'b0;
               txd_o  <= 1'b1;
            end else begin
               bit_i  <= bit_i + 1'b1;
               ph     <= '0;
               sclk_o <= 1'b0;
               txd_o  <= te ? tsr[bit_i + BW'(1)] : 1'b1;
            end
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   AST_OVR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !active) |=> (!active && sclk_o)); // R4
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run_any |=> (sclk_o && txd_o)); // R8
   AST_NO_STORE_AND_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      !(store && ovr_evt)); // R3
   AST_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !start_now) |=> (sclk_o && txd_o)); // R7

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
   parameter int DATA_W = 8,
   parameter int DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sclk_o,
   output logic              txd_o,
   input  logic              rxd_i
);

   logic              te;
   logic              re;
   logic              ovr;
   logic              tx_empty;
   logic              rx_full;
   logic              rd_rdr;
   logic              load;
   logic              store;
   logic              ovr_evt;
   logic [DATA_W-1:0] tdr;
   logic [DATA_W-1:0] rsr;

   sst_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .load     (load),
      .store    (store),
      .ovr_evt  (ovr_evt),
      .rsr      (rsr),
      .rdata    (rdata),
      .te       (te),
      .re       (re),
      .ovr      (ovr),
      .tx_empty (tx_empty),
      .rx_full  (rx_full),
      .tdr      (tdr),
      .rd_rdr   (rd_rdr)
   );

   sst_engine #(.DATA_W(DATA_W), .DIV(DIV)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .te       (te),
      .re       (re),
      .ovr      (ovr),
      .tx_empty (tx_empty),
      .rx_full  (rx_full),
      .rd_rdr   (rd_rdr),
      .tdr      (tdr),
      .rxd      (rxd_i),
      .load     (load),
      .store    (store),
      .ovr_evt  (ovr_evt),
      .rsr      (rsr),
      .sclk_o   (sclk_o),
      .txd_o    (txd_o)
   );

endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam logic [1:0] A_TXD  = 2'd0;
   localparam logic [1:0] A_RXD  = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_CTRL = 2'd3;

   logic          clk;
   logic          rst_n;
   logic          wr_en;
   logic          rd_en;
   logic [1:0]    addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          sclk_o;
   logic          txd_o;
   logic          rxd_i;
   logic          loop;
   logic          ext_bit;
   logic [7:0]    rx_pat;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int cyc = 0, fall_cnt = 0, first_fall = 0, last_fall = 0;
   int rise_cnt = 0, capn = 0, ncap = 0, ext_idx = 0;
   logic [7:0] cap = 8'h00;
   logic [7:0] cap_q [0:63];
   logic prev_sclk = 1'b1;

   assign rxd_i = loop ? txd_o : ext_bit;

   sync_serial_xcvr #(.DATA_W(DW), .DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_sclk && !sclk_o) begin
         fall_cnt = fall_cnt + 1;
         if (fall_cnt == 1) first_fall = cyc;
         last_fall = cyc;
         ext_bit = rx_pat[ext_idx];
         ext_idx = (ext_idx + 1) % 8;
      end
      if (!prev_sclk && sclk_o) begin
         rise_cnt = rise_cnt + 1;
         cap = {txd_o, cap[7:1]};
         capn = capn + 1;
         if (capn == 8) begin
            cap_q[ncap % 64] = cap;
            ncap = ncap + 1;
            capn = 0;
         end
      end
      prev_sclk = sclk_o;
   end

   function automatic logic [7:0] stat_val(input bit txe, input bit rxf, input bit ov);
      return {5'd0, ov, rxf, txe};
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d, input bit side);
      addr = a; rd_en = side;
      #1;
      d = rdata;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val, input string req);
      logic [7:0] s;
      int n;
      n = 0;
      s = 8'h00;
      do begin
         rd(A_STAT, s, 1'b0);
         n++;
      end while (((s & mask) != val) && n < 2000);
      if (n >= 2000) chk_eq(req, int'(s & mask), int'(val));
   endtask

   task automatic wait_rise(input int target);
      int n;
      n = 0;
      while (rise_cnt < target && n < 2000) begin
         tick();
         n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (run): actual 0x0 expected 0x1");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d, b;
      int r0, n0, f0;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h00;
      loop = 1'b1; ext_bit = 1'b1; rx_pat = 8'hFF;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R9: reset values
      rd(A_STAT, d, 1'b0); chk_eq("R9 status", d, stat_val(1, 0, 0));
      rd(A_CTRL, d, 1'b0); chk_eq("R9 control", d, 8'h00);
      chk_eq("R9 idle lines", {sclk_o, txd_o}, 2'b11);

      // R1: write clears transmit-empty
      wr(A_TXD, 8'h5A);
      rd(A_STAT, d, 1'b0); chk_eq("R1 txe cleared", d, stat_val(0, 0, 0));

      // R5: single loopback frame, format and timing
      fall_cnt = 0; capn = 0;
      wr(A_CTRL, 8'h03);
      wait_stat(8'h02, 8'h02, "R5 wait rxf");
      rd(A_RXD, d, 1'b0); chk_eq("R5 received byte", d, 8'h5A);
      chk_eq("R5 serial byte", cap_q[(ncap - 1) % 64], 8'h5A);
      chk_eq("R5 fall count", fall_cnt, 8);
      chk_eq("R5 bit spacing", last_fall - first_fall, 7 * DIV);
      rd(A_STAT, d, 1'b0); chk_eq("R6 txe set after load", d, stat_val(1, 1, 0));
      rd(A_RXD, d, 1'b1);
      rd(A_STAT, d, 1'b0); chk_eq("R2 rxf cleared by read", d, stat_val(1, 0, 0));

      // R6 back-to-back, R3 overrun
      fall_cnt = 0;
      wr(A_TXD, 8'hA1);
      wait_stat(8'h01, 8'h01, "R6 wait load");
      wr(A_TXD, 8'h3C);
      wait_stat(8'h04, 8'h04, "R3 wait ovr");
      chk_eq("R6 gapless falls", fall_cnt, 16);
      chk_eq("R6 gapless spacing", last_fall - first_fall, 15 * DIV);
      chk_eq("R6 second byte sent", cap_q[(ncap - 1) % 64], 8'h3C);
      rd(A_RXD, d, 1'b0); chk_eq("R3 old byte kept", d, 8'hA1);

      // R4: frozen while overrun
      wr(A_TXD, 8'hE7);
      f0 = fall_cnt;
      repeat (5 * DIV) tick();
      chk_eq("R4 no edges during ovr", fall_cnt, f0);
      chk_eq("R4 sclk high during ovr", sclk_o, 1);
      wr(A_STAT, 8'h04);
      rd(A_STAT, d, 1'b0); chk_eq("R4 write one ignored", d, stat_val(0, 1, 1));
      rd(A_RXD, d, 1'b1);
      wr(A_STAT, 8'h00);
      wait_stat(8'h02, 8'h02, "R4 resume");
      rd(A_RXD, d, 1'b1); chk_eq("R4 resumed byte", d, 8'hE7);
      rd(A_STAT, d, 1'b0); chk_eq("R7 status idle", d, stat_val(1, 0, 0));
      chk_eq("R7 lines idle", {sclk_o, txd_o}, 2'b11);

      // R10: read in the frame-end cycle
      wr(A_TXD, 8'h11);
      wait_stat(8'h02, 8'h02, "R10 first");
      r0 = rise_cnt;
      wr(A_TXD, 8'hD4);
      wait_rise(r0 + 8);
      repeat (HALF - 1) tick();
      rd(A_RXD, d, 1'b1); chk_eq("R10 read old", d, 8'h11);
      rd(A_STAT, d, 1'b0); chk_eq("R10 flags", d, stat_val(1, 1, 0));
      rd(A_RXD, d, 1'b1); chk_eq("R10 new byte", d, 8'hD4);

      // R11: write in the load cycle
      wr(A_CTRL, 8'h01);
      r0 = rise_cnt; n0 = ncap;
      wr(A_TXD, 8'h6E);
      wait_stat(8'h01, 8'h01, "R11 load E");
      wr(A_TXD, 8'hF0);
      wait_rise(r0 + 8);
      repeat (HALF - 1) tick();
      wr(A_TXD, 8'h0B);
      rd(A_STAT, d, 1'b0); chk_eq("R11 txe stays 0", d, stat_val(0, 0, 0));
      for (int i = 0; i < 200 && ncap < n0 + 3; i++) tick();
      chk_eq("R11 first", cap_q[n0 % 64], 8'h6E);
      chk_eq("R11 waiting byte", cap_q[(n0 + 1) % 64], 8'hF0);
      chk_eq("R11 written byte", cap_q[(n0 + 2) % 64], 8'h0B);
      repeat (DIV) tick();
      rd(A_STAT, d, 1'b0); chk_eq("R6 txe after last", d, stat_val(1, 0, 0));

      // R12: receive only
      loop = 1'b0; rx_pat = 8'hC3; ext_idx = 0;
      wr(A_CTRL, 8'h02);
      wait_stat(8'h02, 8'h02, "R12 wait");
      rd(A_RXD, d, 1'b0); chk_eq("R12 received", d, 8'hC3);
      wait_stat(8'h04, 8'h04, "R3 rx-only ovr");
      f0 = fall_cnt;
      repeat (3 * DIV) tick();
      chk_eq("R4 rx-only frozen", fall_cnt, f0);
      rd(A_RXD, d, 1'b0); chk_eq("R3 rx-only kept", d, 8'hC3);
      rx_pat = 8'h96;
      rd(A_RXD, d, 1'b1);
      wr(A_STAT, 8'h00);
      wait_stat(8'h02, 8'h02, "R12 second");
      rd(A_RXD, d, 1'b1); chk_eq("R12 second byte", d, 8'h96);

      // R8: disable mid-frame
      for (int i = 0; i < 50 && sclk_o; i++) tick();
      wr(A_CTRL, 8'h00);
      tick();
      chk_eq("R8 lines idle", {sclk_o, txd_o}, 2'b11);
      f0 = fall_cnt;
      repeat (3 * DIV) tick();
      chk_eq("R8 no edges", fall_cnt, f0);

      // R5 random loopback
      loop = 1'b1; capn = 0;
      wr(A_CTRL, 8'h03);
      for (int i = 0; i < 20; i++) begin
         b = 8'($urandom);
         n0 = ncap;
         wr(A_TXD, b);
         wait_stat(8'h02, 8'h02, "R5 random wait");
         rd(A_RXD, d, 1'b1); chk_eq("R5 random rx", d, b);
         chk_eq("R5 random serial", cap_q[n0 % 64], b);
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule